// File: doc/BRIEF.md
# Packed Colour Palette Expander

The block holds a colour lookup table of 256 entries in 128 storage words of 32 bits, two entries to a word. A pixel pipeline gives it an 8-bit entry number and receives a 24-bit colour one clock later. Each entry is a 16-bit half-word with three 5-bit colour fields and one spare flag bit. The block widens each field to 8 bits and can exchange the red and blue channels under a single control input.

Software or a bus bridge fills the table through a word port (word number, 32-bit data, write strobe). The same port reads back any word exactly as it was written. Lookups and word accesses run at the same time on separate ports, so the table can be updated while the display is being scanned.

Top module: `pal_expander`

## Requirements
- R1: Entry e (0..255) comes from storage word e>>1 (0..127). The low half-word, bits [15:0], supplies the even entry and the high half-word, bits [31:16], supplies the odd entry.
- R2: Within a half-word, red is bits [4:0], green is bits [9:5] and blue is bits [14:10]. With `swap_rb` low, `lk_rgb` is red in [23:16], green in [15:8] and blue in [7:0].
- R3: Each 5-bit field widens to 8 bits as the field followed by three zero bits (field * 8).
- R4: Bit 15 of a half-word, the intensity flag, has no effect on the colour output.
- R5: With `swap_rb` high in the lookup cycle, the red field goes to [7:0] and the blue field to [23:16]. Green stays in [15:8].
- R6: `lk_rgb` after clock edge t shows the entry selected by `lk_idx` and `swap_rb` at edge t. It holds that value until the next edge.
- R7: A lookup in the same cycle as a write to its word returns the colour from before the write. The next lookup returns the new colour.
- R8: `rd_data` after edge t holds word `rd_idx` as sampled at edge t, bit for bit as last written. A write to that word in the same cycle is not yet visible.
- R9: While `rst` is high at a clock edge, `lk_rgb` and `rd_data` go to zero. Stored words are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the word port |
| wr_idx | input | 7 | Word number for a write |
| wr_data | input | 32 | Word to be stored |
| rd_idx | input | 7 | Word number for a read-back |
| rd_data | output | 32 | Read-back word, one cycle later |
| swap_rb | input | 1 | Exchange red and blue at the output when high |
| lk_idx | input | 8 | Entry number for a colour lookup |
| lk_rgb | output | 24 | Expanded colour, one cycle later |

## Verification
The bench writes a word and looks up its entry in the same cycle. A design that forwards the new data would show the new colour one cycle early, and the check for old-then-new catches it. Half-words with only bit 15 different go through the lookup, which exposes any leak of the intensity flag into the low bits or into a channel. Single-channel patterns are looked up with `swap_rb` toggled, and odd and even entries are mixed at random. This shows up a swapped half-word select, a green channel moved by the swap, or a field placed at the wrong end of its 8-bit lane. A reset in the middle of the run checks that both outputs go to zero.

// File: rtl/palx_pkg.sv
package palx_pkg;

  localparam int FIELD_W = 5;
  localparam int CHAN_W  = 8;
  localparam int HALF_W  = 16;
  localparam int PAD_W   = CHAN_W - FIELD_W;

  typedef struct packed {
    logic               glow;
    logic [FIELD_W-1:0] blu;
    logic [FIELD_W-1:0] grn;
    logic [FIELD_W-1:0] red;
  } half_entry_t;

  typedef struct packed {
    logic [CHAN_W-1:0] red;
    logic [CHAN_W-1:0] grn;
    logic [CHAN_W-1:0] blu;
  } rgb_t;

  function automatic logic [CHAN_W-1:0] widen(input logic [FIELD_W-1:0] f);
    return {f, {PAD_W{1'b0}}};
  endfunction

endpackage

// File: rtl/pal_store.sv
module pal_store #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_b
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // read-before-write on both read ports
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_a <= '0;
      rdata_b <= '0;
    end else begin
      rdata_a <= mem[raddr_a];
      rdata_b <= mem[raddr_b];
    end
  end

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst)             age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R8: a word written two edges back is what port A returns for it
  assert_readback_R8: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && $past(we, 2) && $past(waddr, 2) == $past(raddr_a))
      |-> rdata_a == $past(wdata, 2));

endmodule

// File: rtl/pal_unpack.sv
module pal_unpack
  import palx_pkg::*;
#(
  parameter int LANES = 2,
  localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LANES*HALF_W-1:0] word,
  input  logic [SEL_W-1:0]        lane_sel,
  input  logic                    swap,
  output rgb_t                    rgb
);
  half_entry_t lane [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane[i] = half_entry_t'(word[i*HALF_W +: HALF_W]);
  end

  half_entry_t pick;
  always_comb begin
    pick = lane[0];
    for (int k = 0; k < LANES; k++) begin
      if (lane_sel == SEL_W'(k)) pick = lane[k];
    end
  end

  logic [CHAN_W-1:0] r8, g8, b8;
  assign r8 = widen(pick.red);
  assign g8 = widen(pick.grn);
  assign b8 = widen(pick.blu);

  always_comb begin
    rgb.grn = g8;
    if (swap) begin
      rgb.red = b8;
      rgb.blu = r8;
    end else begin
      rgb.red = r8;
      rgb.blu = b8;
    end
  end

endmodule

// File: rtl/pal_expander.sv
module pal_expander
  import palx_pkg::*;
#(
  parameter int WORD_IDX_W = 7,
  localparam int LANES       = 2,
  localparam int LANE_SEL_W  = 1,
  localparam int ENTRY_IDX_W = WORD_IDX_W + LANE_SEL_W,
  localparam int DATA_W      = LANES * HALF_W,
  localparam int RGB_W       = 3 * CHAN_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [WORD_IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [WORD_IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0]      rd_data,
  input  logic                   swap_rb,
  input  logic [ENTRY_IDX_W-1:0] lk_idx,
  output logic [RGB_W-1:0]       lk_rgb
);
  logic [DATA_W-1:0]     lk_word;
  logic [LANE_SEL_W-1:0] lane_q;
  logic                  swap_q;
  rgb_t                  colour;

  pal_store #(.ADDR_W(WORD_IDX_W), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .we      (wr_en),
    .waddr   (wr_idx),
    .wdata   (wr_data),
    .raddr_a (rd_idx),
    .rdata_a (rd_data),
    .raddr_b (lk_idx[ENTRY_IDX_W-1:LANE_SEL_W]),
    .rdata_b (lk_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_q <= '0;
      swap_q <= 1'b0;
    end else begin
      lane_q <= lk_idx[LANE_SEL_W-1:0];
      swap_q <= swap_rb;
    end
  end

  pal_unpack #(.LANES(LANES)) u_unpack (
    .word     (lk_word),
    .lane_sel (lane_q),
    .swap     (swap_q),
    .rgb      (colour)
  );

  assign lk_rgb = colour;

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst)             age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R1 R2: lookup and read-back of the same word agree on the green field
  assert_ports_agree_R1: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && $past(lk_idx[ENTRY_IDX_W-1:1]) == $past(rd_idx))
      |-> lk_rgb[15:8] == ($past(lk_idx[0]) ? {rd_data[25:21], 3'b000}
                                            : {rd_data[9:5], 3'b000}));

  // R7: a write shows up in the lookup one edge after the write edge
  assert_new_colour_R7: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && $past(wr_en, 2) && $past(wr_idx, 2) == $past(lk_idx[ENTRY_IDX_W-1:1])
     && !$past(lk_idx[0]) && !$past(swap_rb))
      |-> lk_rgb[23:16] == {$past(wr_data[4:0], 2), 3'b000});

  // R6: unchanged request and table give an unchanged colour
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && $past(lk_idx) == $past(lk_idx, 2)
     && $past(swap_rb) == $past(swap_rb, 2) && !$past(wr_en, 2))
      |-> $stable(lk_rgb));

  // R5: toggling the swap exchanges the outer channels and keeps green
  assert_swap_R5: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && $past(lk_idx) == $past(lk_idx, 2)
     && $past(swap_rb) != $past(swap_rb, 2) && !$past(wr_en, 2))
      |-> (lk_rgb[23:16] == $past(lk_rgb[7:0]) && lk_rgb[7:0] == $past(lk_rgb[23:16])
           && $stable(lk_rgb[15:8])));

endmodule

// File: tb/sim_pal_expander.sv
module sim_pal_expander;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [6:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [6:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic        swap_rb = 1'b0;
  logic [7:0]  lk_idx = '0;
  logic [23:0] lk_rgb;

  always #(PERIOD/2) clk = ~clk;

  pal_expander u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .swap_rb(swap_rb),
    .lk_idx(lk_idx), .lk_rgb(lk_rgb)
  );

  int unsigned mm [128];
  int unsigned exp_lk, exp_rd;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  string tag = "R9";

  function automatic int unsigned colour(int unsigned w, int e, bit sw);
    int unsigned h, r, g, b;
    h = (e % 2 == 1) ? (w >> 16) & 32'hFFFF : w & 32'hFFFF;
    r = (h % 32) * 8;
    g = ((h / 32) % 32) * 8;
    b = ((h / 1024) % 32) * 8;
    if (sw) return b * 65536 + g * 256 + r;
    return r * 65536 + g * 256 + b;
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit chk);
    @(posedge clk);
    if (rst) begin
      exp_lk = 0;
      exp_rd = 0;
    end else begin
      exp_lk = colour(mm[lk_idx[7:1]], int'(lk_idx[0]), swap_rb);
      exp_rd = mm[rd_idx];
    end
    if (wr_en) mm[wr_idx] = wr_data;
    @(negedge clk);
    if (chk) begin
      check(tag, "lookup", {8'h00, lk_rgb}, exp_lk);
      check(tag, "raw", rd_data, exp_rd);
    end
  endtask

  task automatic put(int idx, int unsigned d);
    wr_en = 1'b1; wr_idx = 7'(idx); wr_data = d;
  endtask

  initial begin
    // R9: reset state
    tag = "R9";
    for (int i = 0; i < 3; i++) step(1'b1);
    rst = 1'b0;

    // fill the table (unchecked: read ports still see unwritten words)
    for (int i = 0; i < 128; i++) begin
      put(i, (i * 32'h9E3779B1) ^ (i << 20));
      step(1'b0);
    end
    wr_en = 1'b0;
    step(1'b0);

    // mixed traffic against the model
    tag = "R1 R2 R3 R6 R8";
    for (int i = 0; i < 600; i++) begin
      wr_en   = ($urandom % 10) < 3;
      wr_idx  = 7'($urandom);
      wr_data = $urandom;
      rd_idx  = (i % 7 == 0) ? wr_idx : 7'($urandom);
      lk_idx  = (i % 5 == 0) ? {wr_idx, 1'($urandom)} : 8'($urandom);
      swap_rb = 1'($urandom);
      step(1'b1);
    end
    wr_en = 1'b0; swap_rb = 1'b0;

    // R7: write and lookup of one word in the same cycle
    tag = "R7";
    put(9, 32'h0000_03E0); lk_idx = 8'd18; step(1'b1);
    wr_en = 1'b0; step(1'b1);
    put(9, 32'h0000_001F); step(1'b1);
    check("R7", "old colour", {8'h00, lk_rgb}, 32'h0000_F800);
    wr_en = 1'b0; step(1'b1);
    check("R7", "new colour", {8'h00, lk_rgb}, 32'h00F8_0000);

    // R8: same-cycle read of a word being written returns old
    tag = "R8";
    rd_idx = 7'd9; put(9, 32'hA5A5_5A5A); step(1'b1);
    check("R8", "old word", rd_data, 32'h0000_001F);
    wr_en = 1'b0; step(1'b1);
    check("R8", "new word", rd_data, 32'hA5A5_5A5A);

    // R4: intensity bit ignored, both halves
    tag = "R4";
    put(20, 32'h7C1F_7FFF); lk_idx = 8'd40; step(1'b1);
    wr_en = 1'b0; step(1'b1);
    check("R4", "low clear", {8'h00, lk_rgb}, 32'h00F8_F8F8);
    put(20, 32'hFC1F_FFFF); step(1'b1);
    wr_en = 1'b0; step(1'b1);
    check("R4", "low set", {8'h00, lk_rgb}, 32'h00F8_F8F8);
    lk_idx = 8'd41; step(1'b1);
    check("R4", "high set", {8'h00, lk_rgb}, 32'h00F8_00F8);

    // R3 R1: odd entry, single field values
    tag = "R3";
    put(33, 32'h0001_0000); lk_idx = 8'd67; step(1'b1);
    wr_en = 1'b0; step(1'b1);
    check("R3", "red lsb high half", {8'h00, lk_rgb}, 32'h0008_0000);

    // R5: channel swap
    tag = "R5";
    put(5, 32'h0000_0C1F); lk_idx = 8'd10; step(1'b1);
    wr_en = 1'b0; step(1'b1);
    check("R5", "no swap", {8'h00, lk_rgb}, 32'h00F8_0018);
    swap_rb = 1'b1; step(1'b1);
    check("R5", "swap", {8'h00, lk_rgb}, 32'h0018_00F8);
    swap_rb = 1'b0; step(1'b1);
    check("R5", "swap off", {8'h00, lk_rgb}, 32'h00F8_0018);

    // R9: reset mid-run clears outputs
    tag = "R9";
    rst = 1'b1; step(1'b1);
    check("R9", "lookup zero", {8'h00, lk_rgb}, 32'h0);
    check("R9", "raw zero", rd_data, 32'h0);
    rst = 1'b0; step(1'b1);
    check("R9", "contents kept", {8'h00, lk_rgb}, 32'h00F8_0018);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule